// File: doc/BRIEF.md
# Serial EEPROM Write-Guard and Status Register

This block sits between the serial command decoder of a small EEPROM and its array programming logic. The decoder hands it one decoded command per cycle, at the point where the host closes a frame. The command is one of: latch-set, latch-clear, status write, or array write with target address. The block also sees the level of the active-low write-protect pin. For each status write or array write it decides whether programming may start. When it accepts one, it raises a one-cycle go pulse and runs a self-timed busy window.

The block keeps a small status byte that the decoder returns for status reads. The byte holds a busy flag, the write-enable latch and a two-bit protection level. The protection level fences off the top quarter, the top half or all of the array. That level survives a reset, to model non-volatile storage. The busy flag and the latch start cleared. Once a write is accepted it always runs its full length. A protect-pin fall and any later command leave it untouched.

Top module: `ee_wp_status_ctrl`

## Requirements
- R1: After reset the busy flag and write-enable latch are 0 and commit_go_o is 0; the protection level keeps the value it held before reset (BP_INIT at power-up).
- R2: status_o carries the busy flag in bit 0, the write-enable latch in bit 1, the low protection bit in bit 2, the high protection bit in bit 3; bits 7..4 read 0.
- R3: A latch-set command (cmd_op_i = 1) with wp_n_i high and the block idle sets the latch on the next cycle; a latch-clear command (cmd_op_i = 2) clears it; both act whatever the protection level.
- R4: While wp_n_i is low the latch reads 0 from the next cycle on, and a latch-set command cannot set it.
- R5: A status write (cmd_op_i = 3) is accepted only when idle, with wp_n_i high and the latch set; it then loads cmd_data_i[3:2] into the protection level and ignores cmd_data_i[7:4] and cmd_data_i[1:0].
- R6: An array write (cmd_op_i = 4) is accepted only when idle, with wp_n_i high, the latch set, and cmd_addr_i outside the locked region. Level 0 locks nothing, level 1 locks the top quarter of the address space, level 2 locks the top half, and level 3 locks the whole array.
- R7: An accepted write gives commit_go_o high for one cycle, in the cycle after the command. The busy flag is high from that same cycle for exactly WRITE_CYCLES cycles, and the latch clears in the cycle the busy flag falls.
- R8: A rejected status or array write gives no go pulse and changes neither the latch nor the protection level.
- R9: While the busy flag is high, every command is ignored.
- R10: wp_n_i going low during a busy window does not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin level, low protects |
| cmd_valid_i | input | 1 | A decoded command is present this cycle |
| cmd_op_i | input | 3 | Command code: 1 latch-set, 2 latch-clear, 3 status write, 4 array write |
| cmd_data_i | input | 8 | Data byte of a status write |
| cmd_addr_i | input | ADDR_W | Target address of an array write |
| status_o | output | 8 | Status byte for status reads |
| commit_go_o | output | 1 | One-cycle grant to start programming |

## Verification
A corrupted latch shows up in status bit 1 on the very next cycle. It also shows up in whether the next write is granted, so the cycle-level reference model catches it at once. A wrong protection level shows up in status bits 3:2. It also turns a boundary-address write into the wrong grant decision. The directed writes just below and just above each region edge expose this within one command. A timer that is off by one shows up as a busy window of the wrong length, or as the latch clearing on the wrong cycle. Both appear at the end of the first accepted write.

// File: rtl/ee_wp_pkg.sv
// Shared command codes and status bit positions for the write-guard block.
package ee_wp_pkg;
    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_SET_WEL = 3'd1,
        CMD_CLR_WEL = 3'd2,
        CMD_STAT_WR = 3'd3,
        CMD_ARR_WR  = 3'd4
    } cmd_e;

    localparam int STAT_BUSY  = 0;
    localparam int STAT_LATCH = 1;
    localparam int STAT_LVL0  = 2;
    localparam int STAT_LVL1  = 3;
endpackage

// File: rtl/ee_prot_map.sv
// Decides whether an address falls in the region locked by the protection level.
// Assumes ADDR_W >= 2; regions are aligned quarters of the address space.
module ee_prot_map #(
    parameter int ADDR_W = 9
) (
    input  logic [1:0]        level_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam int TOP = ADDR_W - 1;

    // Compare the top address bits against the region chosen by the level.
    always_comb begin
        unique case (level_i)
            2'b00:   locked_o = 1'b0;
            2'b01:   locked_o = (addr_i[TOP -: 2] == 2'b11);
            2'b10:   locked_o = addr_i[TOP];
            default: locked_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/ee_busy_timer.sv
// Self-timed programming window: loads CYCLES on start and counts to zero.
// Assumes start_i is never asserted while busy_o is high and CYCLES >= 1.
module ee_busy_timer #(
    parameter int CYCLES = 20,
    parameter int CNT_W  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    logic [CNT_W-1:0] left_q;

    // Reload on start, otherwise count down while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (start_i)        left_q <= CNT_W'(CYCLES);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign busy_o = (left_q != '0);
    assign done_o = (left_q == CNT_W'(1));
endmodule

// File: rtl/ee_wp_status_ctrl.sv
// Write-guard and status register for a serial EEPROM.
// Takes one decoded command per cycle from the protocol engine, keeps the
// write-enable latch and protection level, grants programming and runs the
// busy window. The protection level has no reset: it models non-volatile bits.
module ee_wp_status_ctrl #(
    parameter int         ADDR_W       = 9,
    parameter int         WRITE_CYCLES = 20,
    parameter logic [1:0] BP_INIT      = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [7:0]        cmd_data_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    output logic [7:0]        status_o,
    output logic              commit_go_o
);
    import ee_wp_pkg::*;

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    cmd_e       cmd;
    logic       busy, done, locked;
    logic       take, may_write, stat_ok, arr_ok, start;
    logic       latch_q = 1'b0;
    logic [1:0] level_q = BP_INIT;
    logic       go_q    = 1'b0;
    logic       data_unused;

    assign cmd         = cmd_e'(cmd_op_i);
    assign take        = cmd_valid_i && !busy;
    assign may_write   = wp_n_i && latch_q;
    assign stat_ok     = take && (cmd == CMD_STAT_WR) && may_write;
    assign arr_ok      = take && (cmd == CMD_ARR_WR) && may_write && !locked;
    assign start       = stat_ok || arr_ok;
    assign data_unused = ^{cmd_data_i[7:4], cmd_data_i[1:0]};

    ee_prot_map #(.ADDR_W(ADDR_W)) u_map (
        .level_i  (level_q),
        .addr_i   (cmd_addr_i),
        .locked_o (locked)
    );

    ee_busy_timer #(.CYCLES(WRITE_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done)
    );

    // Write-enable latch: pin low and write completion win over commands.
    always_ff @(posedge clk) begin
        if (!rst_n)                                latch_q <= 1'b0;
        else if (!wp_n_i || done)                  latch_q <= 1'b0;
        else if (take && cmd == CMD_SET_WEL)       latch_q <= 1'b1;
        else if (take && cmd == CMD_CLR_WEL)       latch_q <= 1'b0;
    end

    // Protection level: loaded only by an accepted status write, kept over reset.
    always_ff @(posedge clk) begin
        if (rst_n && stat_ok) level_q <= cmd_data_i[3:2];
    end

    // One-cycle programming grant, aligned with the busy flag rising.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= start;
    end

    // Assemble the status byte.
    always_comb begin
        status_o             = '0;
        status_o[STAT_BUSY]  = busy;
        status_o[STAT_LATCH] = latch_q;
        status_o[STAT_LVL0]  = level_q[0];
        status_o[STAT_LVL1]  = level_q[1];
    end

    assign commit_go_o = go_q;
endmodule

// File: rtl/ee_wp_status_chk.sv
// Port-level assertions for ee_wp_status_ctrl, attached by bind.
module ee_wp_status_chk #(
    parameter int WRITE_CYCLES = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n_i,
    input logic       cmd_valid_i,
    input logic [2:0] cmd_op_i,
    input logic [7:0] status_o,
    input logic       commit_go_o
);
    int run_q;

    // Length of the current busy run, checked against the window size.
    always_ff @(posedge clk) begin
        if (!rst_n || !status_o[0]) run_q <= 0;
        else                        run_q <= run_q + 1;
    end

    p_go_with_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> commit_go_o);
    p_window_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> (run_q == WRITE_CYCLES));
    p_latch_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> !status_o[1]);
    p_pin_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_i |=> !status_o[1]);
    p_grant_needs_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go_o |-> ($past(status_o[1]) && $past(wp_n_i) && $past(cmd_valid_i)));
    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |=> !commit_go_o);
    p_level_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] != $past(status_o[3:2])) |->
            ($past(cmd_valid_i) && $past(cmd_op_i) == 3'd3 && commit_go_o));
    p_high_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go_o |-> (status_o[7:4] == 4'h0));
endmodule

bind ee_wp_status_ctrl ee_wp_status_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_n_i      (wp_n_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .status_o    (status_o),
    .commit_go_o (commit_go_o)
);

// File: tb/tb_ee_wp_status_ctrl.sv
module tb_ee_wp_status_ctrl;
    localparam int ADDR_W = 9;
    localparam int WCYC   = 20;
    localparam int SIZE   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wp_n = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [7:0]        cmd_data = 8'h00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        status;
    logic              go;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    int m_left = 0;
    int m_wel  = 0;
    int m_bp   = 0;
    int m_go   = 0;

    always #2 clk = ~clk;

    ee_wp_status_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WCYC), .BP_INIT(2'b00)) dut (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .cmd_valid_i(cmd_valid),
        .cmd_op_i(cmd_op), .cmd_data_i(cmd_data), .cmd_addr_i(cmd_addr),
        .status_o(status), .commit_go_o(go)
    );

    function automatic bit locked(int bp, int a);
        if (bp == 0) return 0;
        if (bp == 1) return a >= (SIZE / 4) * 3;
        if (bp == 2) return a >= SIZE / 2;
        return 1;
    endfunction

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        automatic int busy = (m_left > 0);
        automatic int wel0 = m_wel;
        m_go = 0;
        if (!rst_n) begin
            m_left = 0; m_wel = 0;
        end else begin
            if (m_left == 1) m_wel = 0;
            if (m_left > 0) m_left--;
            if (!busy && cmd_valid) begin
                case (cmd_op)
                    3'd1: m_wel = 1;
                    3'd2: m_wel = 0;
                    3'd3: if (wp_n && wel0) begin m_bp = cmd_data[3:2]; m_left = WCYC; m_go = 1; end
                    3'd4: if (wp_n && wel0 && !locked(m_bp, cmd_addr)) begin m_left = WCYC; m_go = 1; end
                    default: ;
                endcase
            end
            if (!wp_n) m_wel = 0;
        end
    end

    // Compare against the model every cycle, away from the clock edge.
    always begin
        @(negedge clk); #1;
        begin
            automatic logic [7:0] exp_s = {4'h0, 2'(m_bp), 1'(m_wel), 1'(m_left > 0)};
            checks++;
            if (status !== exp_s || go !== 1'(m_go)) begin
                errors++;
                $display("FAIL R2/R7 model: status=%02h go=%0d expected status=%02h go=%0d at %0t",
                         status, go, exp_s, m_go, $time);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(int op, int data = 0, int addr = 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_data = 8'(data); cmd_addr = ADDR_W'(addr);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic wait_idle();
        while (status[0]) @(negedge clk);
    endtask

    task automatic set_level(int lvl);
        cmd(1);
        cmd(3, lvl << 2);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset go", go, 0);

        cmd(1);
        chk("R3 set latch", status, 8'h02);
        cmd(2);
        chk("R3 clear latch", status, 8'h00);

        // Status write with read-only bits and high nibble set in the data
        cmd(1);
        cmd(3, 8'hFB);
        chk("R7 go pulse on status write", go, 1);
        chk("R5 level loaded, R2 layout", status, 8'h0B);
        begin
            int n = 0;
            while (status[0]) begin n++; @(negedge clk); end
            chk("R7 busy window length", n, WCYC);
            chk("R7 latch cleared at end", status, 8'h08);
        end

        // Level 2 (top half locked)
        cmd(1);
        chk("R3 set latch with level 2", status, 8'h0A);
        cmd(4, 0, 9'h100);
        chk("R8 no go on locked write", go, 0);
        chk("R8 latch kept after reject", status, 8'h0A);
        cmd(4, 0, 9'h0FF);
        chk("R6 unlocked write granted", go, 1);
        cmd(2);
        chk("R9 clear ignored while busy", status[1], 1);
        @(negedge clk); wp_n = 1'b0;
        @(negedge clk);
        chk("R4 pin low clears latch", status[1], 0);
        chk("R10 still busy after pin fall", status[0], 1);
        wait_idle();
        cmd(1);
        chk("R4 set blocked while pin low", status[1], 0);
        wp_n = 1'b1;
        cmd(1);
        cmd(3, 8'h04);
        chk("R5 status write refused while pin low earlier? granted now", go, 1);
        wait_idle();
        chk("R5 level 1 loaded", status, 8'h04);

        // Level 1 boundaries
        cmd(1);
        cmd(4, 0, 9'h180);
        chk("R6 top quarter locked", go, 0);
        cmd(4, 0, 9'h17F);
        chk("R6 below top quarter granted", go, 1);
        wait_idle();

        set_level(3);
        chk("R5 level 3 loaded", status, 8'h0C);
        cmd(1);
        cmd(4, 0, 9'h000);
        chk("R6 level 3 locks address 0", go, 0);
        cmd(2);
        chk("R3 clear with level 3", status, 8'h0C);
        cmd(4, 0, 9'h000);
        chk("R6 latch clear refuses write", go, 0);
        cmd(3, 0);
        chk("R8 status write refused without latch", status, 8'h0C);

        cmd(1);
        cmd(3, 8'h00);
        wait_idle();
        cmd(1);
        cmd(4, 0, 9'h1FF);
        chk("R6 level 0 top address granted", go, 1);
        wait_idle();

        // Reset keeps the level
        set_level(2);
        cmd(1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 level kept over reset", status, 8'h08);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule